// File: doc/BRIEF.md
# Frame-Aligned Serial ADC Word Assembler

This block rebuilds parallel ADC samples from a serial link that carries two lanes: a data lane and a frame-marker lane. Each lane delivers one bit per fast clock cycle, already sampled. Both lanes are shifted into half-sample groups. The two lanes share one group counter, so their group boundaries always move together. The frame lane is high for the first half of every sample period and low for the second half.

After reset the block searches for the word boundary. It looks at each captured frame group. A mixed group (some ones and some zeros) means the boundary is wrong. The block then holds the group counter for one cycle, which moves the boundary by one bit. It then lets two group periods pass before it judges the frame lane again. When enough uniform frame groups arrive in a row, the block declares lock. From then on, the frame group value steers the assembly: the data half captured beside an all-ones frame group becomes the upper half, and the data half captured beside the next all-zeros frame group completes the sample.

The output is a stream with a valid strobe and no ready. A converter cannot be paused, so the consumer must take every sample in the cycle its strobe is high. The block applies no back-pressure and holds no queue.

Top module: `frame_adc_assembler`

## Requirements
- R1: `SAMPLE_W` selects a 14-bit or 12-bit sample. Each lane is cut into groups of `SAMPLE_W/2` bits. Within a group the earliest received bit is the most significant.
- R2: The data and frame lanes are captured with identical group timing. Every transmitted sample, with its bits sent MSB first, appears unchanged on `sample_data` once lock is held.
- R3: A slip is issued only while searching, and only after a frame group that is neither all zeros nor all ones. Each slip moves the group boundary by exactly one bit. Two slips are at least two group periods apart.
- R4: `aligned` rises after 4 consecutive frame groups that are all zeros or all ones. It rises only in the cycle after a group capture.
- R5: While locked, the data group captured with an all-ones frame group is the upper half. The data group captured with the following all-zeros frame group is the lower half. They are joined as {upper, lower}.
- R6: `sample_valid` is a one-cycle pulse, one per assembled sample, and is high only while `aligned` is high. There is no ready input.
- R7: While locked, `aligned` clears and the search restarts after 4 consecutive mixed frame groups. Fewer than 4 mixed groups leave `aligned` high.
- R8: If a search issues `SAMPLE_W/2` slips without reaching lock, `align_err` is set. The search continues, and `align_err` stays high until reset, even after a later lock.
- R9: A synchronous `rst` clears the shift registers, the group counter, the slip counter, `aligned`, `align_err` and `sample_valid`, and returns the block to searching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock; one bit per lane per cycle |
| rst | input | 1 | Synchronous reset, active high |
| data_bit | input | 1 | Sampled bit of the data lane |
| frame_bit | input | 1 | Sampled bit of the frame-marker lane |
| sample_data | output | SAMPLE_W | Assembled sample, valid with `sample_valid` |
| sample_valid | output | 1 | One-cycle strobe per assembled sample |
| aligned | output | 1 | Word boundary locked |
| align_err | output | 1 | Sticky: a full cycle of slips passed without lock |

## Verification
The assertions check these rules on every cycle:
- Slips occur only while unlocked, and at least two group periods apart.
- `aligned` rises and `sample_valid` fires only right after a group capture.
- `sample_valid` never lasts two cycles and is never high without `aligned`.
- `align_err` never falls outside reset, and reset clears all flags.

Only the bench scenarios can show that the assembled words equal the transmitted samples, in order, for both sample widths and for random starting bit offsets. The same holds for the following:
- A short run of bad frame groups leaves lock intact, while a long run drops it.
- A frame lane that can never align raises the error flag.

// File: rtl/fadc_pkg.sv
package fadc_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCKED = 2'd2
  } align_state_t;
endpackage

// File: rtl/fadc_group_timer.sv
// Shared group counter for both lanes; a slip holds it for one cycle.
module fadc_group_timer #(
  parameter int HALF_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic slip,
  output logic cap_now,
  output logic grp_stb
);
  localparam int CNT_W = $clog2(HALF_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_W - 1);

  logic [CNT_W-1:0] cnt_q;

  assign cap_now = (cnt_q == LAST) && !slip;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      grp_stb <= 1'b0;
    end else begin
      grp_stb <= cap_now;
      if (!slip) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fadc_lane_shifter.sv
// One lane: bit history plus a group register loaded on cap_now (earliest bit = MSB).
module fadc_lane_shifter #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              cap_now,
  output logic [HALF_W-1:0] grp
);
  logic [HALF_W-2:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      grp    <= '0;
    end else begin
      hist_q <= {hist_q[HALF_W-3:0], bit_in};
      if (cap_now) grp <= {hist_q, bit_in};
    end
  end
endmodule

// File: rtl/fadc_align_fsm.sv
// Boundary search, lock and unlock decisions from the frame-lane group.
module fadc_align_fsm
  import fadc_pkg::*;
#(
  parameter int HALF_W        = 7,
  parameter int LOCK_GROUPS   = 4,
  parameter int UNLOCK_GROUPS = 4,
  parameter int SETTLE_GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_stb,
  input  logic [HALF_W-1:0] frm_grp,
  output logic              slip,
  output logic              aligned,
  output logic              align_err
);
  localparam int RUN_W  = $clog2(LOCK_GROUPS + UNLOCK_GROUPS + 1);
  localparam int SLIP_W = $clog2(HALF_W + 1);
  localparam int SET_W  = $clog2(SETTLE_GROUPS + 1);
  localparam logic [RUN_W-1:0]  LOCK_LAST   = RUN_W'(LOCK_GROUPS - 1);
  localparam logic [RUN_W-1:0]  UNLOCK_LAST = RUN_W'(UNLOCK_GROUPS - 1);
  localparam logic [SLIP_W-1:0] SLIP_LAST   = SLIP_W'(HALF_W - 1);
  localparam logic [SET_W-1:0]  SET_LAST    = SET_W'(SETTLE_GROUPS - 1);

  align_state_t      state_q;
  logic [RUN_W-1:0]  run_q;
  logic [SLIP_W-1:0] slips_q;
  logic [SET_W-1:0]  settle_q;
  logic              marker_ok;

  assign marker_ok = (&frm_grp) | ~(|frm_grp);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_SEARCH;
      run_q     <= '0;
      slips_q   <= '0;
      settle_q  <= '0;
      slip      <= 1'b0;
      aligned   <= 1'b0;
      align_err <= 1'b0;
    end else begin
      slip <= 1'b0;
      if (grp_stb) begin
        case (state_q)
          ST_SEARCH: begin
            if (marker_ok) begin
              if (run_q == LOCK_LAST) begin
                state_q <= ST_LOCKED;
                aligned <= 1'b1;
                run_q   <= '0;
                slips_q <= '0;
              end else begin
                run_q <= run_q + 1'b1;
              end
            end else begin
              slip     <= 1'b1;
              run_q    <= '0;
              settle_q <= '0;
              state_q  <= ST_SETTLE;
              if (slips_q == SLIP_LAST) begin
                slips_q   <= '0;
                align_err <= 1'b1;
              end else begin
                slips_q <= slips_q + 1'b1;
              end
            end
          end
          ST_SETTLE: begin
            if (settle_q == SET_LAST) state_q <= ST_SEARCH;
            else                      settle_q <= settle_q + 1'b1;
          end
          ST_LOCKED: begin
            if (marker_ok) begin
              run_q <= '0;
            end else if (run_q == UNLOCK_LAST) begin
              state_q <= ST_SEARCH;
              aligned <= 1'b0;
              run_q   <= '0;
              slips_q <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end
          default: state_q <= ST_SEARCH;
        endcase
      end
    end
  end
endmodule

// File: rtl/fadc_half_joiner.sv
// Joins an upper (frame all ones) and a lower (frame all zeros) data half.
module fadc_half_joiner #(
  parameter int HALF_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                grp_stb,
  input  logic                aligned,
  input  logic [HALF_W-1:0]   frm_grp,
  input  logic [HALF_W-1:0]   dat_grp,
  output logic [2*HALF_W-1:0] sample,
  output logic                valid
);
  logic [HALF_W-1:0] upper_q;
  logic              have_upper_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q      <= '0;
      have_upper_q <= 1'b0;
      sample       <= '0;
      valid        <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (grp_stb && aligned) begin
        if (&frm_grp) begin
          upper_q      <= dat_grp;
          have_upper_q <= 1'b1;
        end else if (~(|frm_grp) && have_upper_q) begin
          sample       <= {upper_q, dat_grp};
          valid        <= 1'b1;
          have_upper_q <= 1'b0;
        end else begin
          have_upper_q <= 1'b0;
        end
      end else if (!aligned) begin
        have_upper_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_adc_assembler.sv
module frame_adc_assembler #(
  parameter int SAMPLE_W      = 14,
  parameter int LOCK_GROUPS   = 4,
  parameter int UNLOCK_GROUPS = 4,
  parameter int SETTLE_GROUPS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                data_bit,
  input  logic                frame_bit,
  output logic [SAMPLE_W-1:0] sample_data,
  output logic                sample_valid,
  output logic                aligned,
  output logic                align_err
);
  localparam int HALF_W   = SAMPLE_W / 2;
  localparam int LANE_DAT = 0;
  localparam int LANE_FRM = 1;

  logic              slip_w;
  logic              cap_now;
  logic              grp_stb;
  logic [1:0]        lane_bit;
  logic [HALF_W-1:0] lane_grp [2];

  assign lane_bit[LANE_DAT] = data_bit;
  assign lane_bit[LANE_FRM] = frame_bit;

  fadc_group_timer #(.HALF_W(HALF_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .slip    (slip_w),
    .cap_now (cap_now),
    .grp_stb (grp_stb)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    fadc_lane_shifter #(.HALF_W(HALF_W)) shifter_i (
      .clk     (clk),
      .rst     (rst),
      .bit_in  (lane_bit[g]),
      .cap_now (cap_now),
      .grp     (lane_grp[g])
    );
  end

  fadc_align_fsm #(
    .HALF_W        (HALF_W),
    .LOCK_GROUPS   (LOCK_GROUPS),
    .UNLOCK_GROUPS (UNLOCK_GROUPS),
    .SETTLE_GROUPS (SETTLE_GROUPS)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .grp_stb   (grp_stb),
    .frm_grp   (lane_grp[LANE_FRM]),
    .slip      (slip_w),
    .aligned   (aligned),
    .align_err (align_err)
  );

  fadc_half_joiner #(.HALF_W(HALF_W)) joiner_i (
    .clk     (clk),
    .rst     (rst),
    .grp_stb (grp_stb),
    .aligned (aligned),
    .frm_grp (lane_grp[LANE_FRM]),
    .dat_grp (lane_grp[LANE_DAT]),
    .sample  (sample_data),
    .valid   (sample_valid)
  );
endmodule

// File: rtl/frame_adc_assembler_chk.sv
module frame_adc_assembler_chk #(
  parameter int HALF_W = 7
) (
  input logic clk,
  input logic rst,
  input logic slip,
  input logic grp_stb,
  input logic sample_valid,
  input logic aligned,
  input logic align_err
);
  localparam int SAT = 2 * HALF_W;
  logic [15:0] since_slip_q;

  always_ff @(posedge clk) begin
    if (rst)                     since_slip_q <= 16'(SAT);
    else if (slip)               since_slip_q <= '0;
    else if (since_slip_q < SAT) since_slip_q <= since_slip_q + 1'b1;
  end

  // R3
  slip_only_searching_chk: assert property (@(posedge clk) disable iff (rst)
    slip |-> !aligned);

  // R3
  slip_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    slip |-> (since_slip_q >= 16'(SAT)));

  // R4
  lock_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(grp_stb));

  // R6
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> aligned);

  // R6
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R5
  valid_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(grp_stb));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |=> align_err);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!aligned && !sample_valid && !align_err));
endmodule

bind frame_adc_assembler frame_adc_assembler_chk #(.HALF_W(HALF_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .slip         (slip_w),
  .grp_stb      (grp_stb),
  .sample_valid (sample_valid),
  .aligned      (aligned),
  .align_err    (align_err)
);

// File: tb/frame_adc_assembler_tb_top.sv
module frame_adc_assembler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbit [2];
  logic fbit [2];

  logic [13:0] samp_a;
  logic [11:0] samp_b;
  logic        vld [2];
  logic        alg [2];
  logic        err [2];
  logic [13:0] smp [2];

  int n_checks = 0;
  int n_fail   = 0;
  int mode     = 0;    // 0: framed stream, 1: frame lane toggles every bit
  int bit_idx  = 0;
  int base_v   = 0;
  int offs  [2];
  bit have_ref [2];
  int exp_n [2];
  int nsmp  [2];
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_adc_assembler #(.SAMPLE_W(14)) dut_i (
    .clk(clk), .rst(rst), .data_bit(dbit[0]), .frame_bit(fbit[0]),
    .sample_data(samp_a), .sample_valid(vld[0]), .aligned(alg[0]), .align_err(err[0]));

  frame_adc_assembler #(.SAMPLE_W(12)) dut12_i (
    .clk(clk), .rst(rst), .data_bit(dbit[1]), .frame_bit(fbit[1]),
    .sample_data(samp_b), .sample_valid(vld[1]), .aligned(alg[1]), .align_err(err[1]));

  assign smp[0] = samp_a;
  assign smp[1] = {2'b00, samp_b};

  function automatic int sw_of(int i);
    return (i == 0) ? 14 : 12;
  endfunction

  function automatic logic [13:0] sample_val(int n, int sw);
    int unsigned v;
    v = (n * 37 + base_v) & ((1 << sw) - 1);
    return v[13:0];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // stream driver
  initial begin
    for (int i = 0; i < 2; i++) begin dbit[i] = 1'b0; fbit[i] = 1'b0; end
  end
  always @(negedge clk) begin
    bit_idx++;
    for (int i = 0; i < 2; i++) begin
      int sw, pos, p;
      logic [13:0] v;
      sw  = sw_of(i);
      pos = bit_idx + offs[i];
      p   = pos % sw;
      v   = sample_val(pos / sw, sw);
      if (mode == 0) begin
        fbit[i] = (p < sw / 2);
        dbit[i] = v[sw-1-p];
      end else begin
        fbit[i] = bit_idx[0];
        dbit[i] = bit_idx[1];
      end
    end
  end

  // output monitor: R2, R5, R6
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) have_ref[i] = 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!alg[i]) have_ref[i] = 1'b0;
        if (vld[i] === 1'b1) begin
          nsmp[i]++;
          chk(alg[i] === 1'b1, "R6", "valid without aligned", int'(alg[i]), 1);
          if (have_ref[i]) begin
            chk(smp[i] == sample_val(exp_n[i], sw_of(i)), "R2/R5",
                $sformatf("sample w%0d", sw_of(i)), int'(smp[i]),
                int'(sample_val(exp_n[i], sw_of(i))));
            exp_n[i]++;
          end else begin
            int cur;
            bit found;
            cur   = (bit_idx + offs[i]) / sw_of(i);
            found = 1'b0;
            for (int k = cur - 4; k <= cur; k++) begin
              if (!found && smp[i] == sample_val(k, sw_of(i))) begin
                found = 1'b1;
                exp_n[i] = k + 1;
              end
            end
            chk(found, "R5", $sformatf("first sample w%0d matches a sent one", sw_of(i)),
                int'(smp[i]), int'(sample_val(cur - 1, sw_of(i))));
            have_ref[i] = found;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wait_aligned(string req);
    int t;
    t = 0;
    while (!(alg[0] && alg[1]) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(alg[0] === 1'b1, req, "lock reached w14", int'(alg[0]), 1);
    chk(alg[1] === 1'b1, req, "lock reached w12", int'(alg[1]), 1);
  endtask

  task automatic new_offsets();
    offs[0] = int'($urandom % 14);
    offs[1] = int'($urandom % 12);
  endtask

  initial begin
    int v0, v1;
    base_v = int'($urandom(32'd4711) % 500);
    new_offsets();
    repeat (4) @(negedge clk);
    // R9: state during reset
    for (int i = 0; i < 2; i++) begin
      chk(alg[i] === 1'b0, "R9", "aligned in reset", int'(alg[i]), 0);
      chk(vld[i] === 1'b0, "R9", "valid in reset", int'(vld[i]), 0);
      chk(err[i] === 1'b0, "R9", "err in reset", int'(err[i]), 0);
    end
    rst = 1'b0;

    // R1 R3 R4: search from random offsets on both widths
    wait_aligned("R4");
    for (int i = 0; i < 2; i++)
      chk(err[i] === 1'b0, "R3", "no error when lock found", int'(err[i]), 0);
    nsmp[0] = 0; nsmp[1] = 0;
    repeat (800) @(negedge clk);
    chk(nsmp[0] > 40, "R1", "samples seen w14", nsmp[0], 41);
    chk(nsmp[1] > 40, "R1", "samples seen w12", nsmp[1], 41);

    // R7: brief corruption keeps lock, long corruption drops it
    mode = 1;
    v0 = nsmp[0]; v1 = nsmp[1];
    repeat (10) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(alg[i] === 1'b1, "R7", "lock held after few bad groups", int'(alg[i]), 1);
    repeat (50) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(alg[i] === 1'b0, "R7", "lock dropped after 4 bad groups", int'(alg[i]), 0);

    // R8: frame lane can never align -> error after a full slip cycle
    repeat (500) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(err[i] === 1'b1, "R8", "error after full slip cycle", int'(err[i]), 1);
      chk(alg[i] === 1'b0, "R8", "still searching", int'(alg[i]), 0);
    end
    chk(nsmp[0] == v0, "R6", "no samples while unlocked w14", nsmp[0], v0);
    chk(nsmp[1] == v1, "R6", "no samples while unlocked w12", nsmp[1], v1);

    // R8: recovery keeps the sticky error
    new_offsets();
    mode = 0;
    wait_aligned("R8");
    for (int i = 0; i < 2; i++)
      chk(err[i] === 1'b1, "R8", "error sticky after lock", int'(err[i]), 1);
    repeat (400) @(negedge clk);

    // R9 + random offsets: reset clears, relock from new boundaries
    for (int r = 0; r < 4; r++) begin
      rst = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        chk(err[i] === 1'b0, "R9", "err cleared by reset", int'(err[i]), 0);
        chk(alg[i] === 1'b0, "R9", "aligned cleared by reset", int'(alg[i]), 0);
      end
      if (r == 0) begin offs[0] = 0; offs[1] = 0; end
      else new_offsets();
      rst = 1'b0;
      v0 = nsmp[0]; v1 = nsmp[1];
      wait_aligned("R3");
      repeat (300) @(negedge clk);
      chk(nsmp[0] > v0 + 10, "R2", "samples after relock w14", nsmp[0] - v0, 11);
      chk(nsmp[1] > v1 + 10, "R2", "samples after relock w12", nsmp[1] - v1, 11);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule